// File: doc/BRIEF.md
# Byte-Command Capture Host Controller

This block runs a capture session for a host on the far side of a byte-wide serial link. It talks to a separate UART transmitter and receiver through valid/ready byte handshakes. It also drives a capture engine through a one-cycle arm pulse and a done pulse, and it reads a 128-entry capture buffer through a synchronous read port.

Coming out of reset, the controller announces itself with the byte 0x72 and then arms the engine. When the engine reports completion, the controller sends 0x66 and waits for commands. The command 0x54 makes it walk the buffer from address 0 to the last address and send every stored byte in turn. The command 0x52 restarts the session: ready byte, arm, finish byte. Every other byte is dropped. Bytes that arrive while the controller is not idle are accepted and discarded.

Top module: `capture_host_ctrl`

## Requirements
- R1: After reset, the first byte offered on the transmit port is 0x72, and `cap_arm` pulses exactly once, in the cycle after that byte is accepted.
- R2: A `cap_done` pulse while the controller waits for capture leads to the byte 0x66 being sent, after which the controller is idle.
- R3: In idle, a received 0x52 restarts the session: 0x72 is sent again, `cap_arm` pulses once more, and 0x66 follows when capture completes.
- R4: In idle, a received 0x54 produces exactly DEPTH transmitted bytes, byte k being the buffer content at address k, for k from 0 upward.
- R5: In idle, any received byte other than 0x52 and 0x54 causes no transmission and no arm pulse, and the controller stays idle.
- R6: After a dump has finished, a further 0x54 repeats the identical dump.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change on the next cycle.
- R8: Bytes received during capture or during a dump are discarded and change neither the byte stream nor the number of arm pulses.
- R9: `buf_ren` is a single-cycle pulse that never overlaps `tx_valid`; the buffer answers one cycle after the read, and that answer is the byte sent.
- R10: `cap_arm` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | output | 8 | Byte offered to the UART transmitter |
| tx_valid | output | 1 | Transmit byte is valid |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| rx_data | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Controller takes received bytes (high after reset) |
| cap_arm | output | 1 | One-cycle pulse that starts a capture |
| cap_done | input | 1 | One-cycle pulse from the engine when capture is complete |
| buf_ren | output | 1 | Buffer read enable |
| buf_raddr | output | 7 | Buffer read address |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after `buf_ren` |

## Verification
A sequencer that ends up in the wrong state shows up first as a wrong or missing byte at the transmit port, often within one handshake: a finish byte before an arm pulse, or an arm pulse that does not follow an accepted ready byte. A dump pointer that is off by one, or a read that is sampled a cycle early, gives a byte stream shifted against the buffer contents. With address-dependent buffer contents, this is visible at the first or the last byte of the dump. A decoder that wrongly stays enabled outside idle shows up later, as extra bytes or an extra arm pulse once the current capture or dump ends. For that reason, the byte and pulse counts are compared over whole sessions.

// File: rtl/chc_pkg.sv
package chc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_READY  = 8'h72;
  localparam logic [BYTE_W-1:0] CODE_FINISH = 8'h66;
  localparam logic [BYTE_W-1:0] CMD_RESTART = 8'h52;
  localparam logic [BYTE_W-1:0] CMD_DUMP    = 8'h54;

  typedef enum logic [3:0] {
    ST_RDY_LOAD,
    ST_RDY_WAIT,
    ST_CAPTURE,
    ST_FIN_LOAD,
    ST_FIN_WAIT,
    ST_IDLE,
    ST_XF_READ,
    ST_XF_LAT,
    ST_XF_LOAD,
    ST_XF_WAIT
  } chc_state_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_RST,
    CMD_XFER
  } chc_cmd_e;
endpackage

// File: rtl/chc_tx_stage.sv
module chc_tx_stage
  import chc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              accepted
);
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= load_byte;
    end else if (valid_q && tx_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign tx_valid = valid_q;
  assign tx_data  = data_q;
  assign accepted = valid_q & tx_ready;
endmodule

// File: rtl/chc_cmd_decode.sv
module chc_cmd_decode
  import chc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output chc_cmd_e          cmd
);
  logic     ready_q;
  chc_cmd_e cmd_q;
  chc_cmd_e cmd_d;

  always_comb begin
    cmd_d = CMD_NONE;
    if (enable && (cmd_q == CMD_NONE) && rx_valid && ready_q) begin
      if (rx_data == CMD_RESTART)   cmd_d = CMD_RST;
      else if (rx_data == CMD_DUMP) cmd_d = CMD_XFER;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      cmd_q   <= CMD_NONE;
    end else begin
      ready_q <= 1'b1;
      cmd_q   <= cmd_d;
    end
  end

  assign rx_ready = ready_q;
  assign cmd      = cmd_q;
endmodule

// File: rtl/chc_addr_ctr.sv
module chc_addr_ctr #(
  parameter int DEPTH = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst || clear) addr_q <= '0;
    else if (step)    addr_q <= (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
  end

  assign addr = addr_q;
  assign last = (addr_q == LAST_ADDR);
endmodule

// File: rtl/chc_seq.sv
module chc_seq
  import chc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_accepted,
  input  logic              cap_done,
  input  chc_cmd_e          cmd,
  input  logic              addr_last,
  input  logic [BYTE_W-1:0] buf_rdata,
  output logic              decode_en,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              addr_clear,
  output logic              addr_step,
  output logic              cap_arm,
  output logic              buf_ren
);
  chc_state_e state_q, state_d;
  logic       arm_q, arm_d;
  logic       ren_q, ren_d;

  always_comb begin
    state_d    = state_q;
    tx_load    = 1'b0;
    tx_byte    = '0;
    addr_clear = 1'b0;
    addr_step  = 1'b0;
    arm_d      = 1'b0;
    ren_d      = 1'b0;
    decode_en  = (state_q == ST_IDLE);
    unique case (state_q)
      ST_RDY_LOAD: begin
        tx_load = 1'b1;
        tx_byte = CODE_READY;
        state_d = ST_RDY_WAIT;
      end
      ST_RDY_WAIT: if (tx_accepted) begin
        arm_d   = 1'b1;
        state_d = ST_CAPTURE;
      end
      ST_CAPTURE: if (cap_done) state_d = ST_FIN_LOAD;
      ST_FIN_LOAD: begin
        tx_load = 1'b1;
        tx_byte = CODE_FINISH;
        state_d = ST_FIN_WAIT;
      end
      ST_FIN_WAIT: if (tx_accepted) state_d = ST_IDLE;
      ST_IDLE: begin
        if (cmd == CMD_RST) begin
          state_d = ST_RDY_LOAD;
        end else if (cmd == CMD_XFER) begin
          addr_clear = 1'b1;
          state_d    = ST_XF_READ;
        end
      end
      ST_XF_READ: begin
        ren_d   = 1'b1;
        state_d = ST_XF_LAT;
      end
      ST_XF_LAT: state_d = ST_XF_LOAD;
      ST_XF_LOAD: begin
        tx_load = 1'b1;
        tx_byte = buf_rdata;
        state_d = ST_XF_WAIT;
      end
      ST_XF_WAIT: if (tx_accepted) begin
        if (addr_last) begin
          state_d = ST_IDLE;
        end else begin
          addr_step = 1'b1;
          state_d   = ST_XF_READ;
        end
      end
      default: state_d = ST_RDY_LOAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RDY_LOAD;
      arm_q   <= 1'b0;
      ren_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      arm_q   <= arm_d;
      ren_q   <= ren_d;
    end
  end

  assign cap_arm = arm_q;
  assign buf_ren = ren_q;
endmodule

// File: rtl/capture_host_ctrl.sv
module capture_host_ctrl
  import chc_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              cap_arm,
  input  logic              cap_done,
  output logic              buf_ren,
  output logic [AW-1:0]     buf_raddr,
  input  logic [BYTE_W-1:0] buf_rdata
);
  chc_cmd_e          cmd;
  logic              decode_en;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_accepted;
  logic              addr_clear;
  logic              addr_step;
  logic              addr_last;

  chc_cmd_decode u_decode (
    .clk      (clk),
    .rst      (rst),
    .enable   (decode_en),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .cmd      (cmd)
  );

  chc_addr_ctr #(.DEPTH(DEPTH)) u_addr (
    .clk   (clk),
    .rst   (rst),
    .clear (addr_clear),
    .step  (addr_step),
    .addr  (buf_raddr),
    .last  (addr_last)
  );

  chc_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .tx_accepted (tx_accepted),
    .cap_done    (cap_done),
    .cmd         (cmd),
    .addr_last   (addr_last),
    .buf_rdata   (buf_rdata),
    .decode_en   (decode_en),
    .tx_load     (tx_load),
    .tx_byte     (tx_byte),
    .addr_clear  (addr_clear),
    .addr_step   (addr_step),
    .cap_arm     (cap_arm),
    .buf_ren     (buf_ren)
  );

  chc_tx_stage u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (tx_load),
    .load_byte (tx_byte),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .accepted  (tx_accepted)
  );
endmodule

// File: rtl/capture_host_ctrl_chk.sv
module capture_host_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       cap_arm,
  input logic       buf_ren
);
  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_arm_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cap_arm |=> !cap_arm);

  assert_arm_after_ready_R1: assert property (@(posedge clk) disable iff (rst)
    cap_arm |-> $past(tx_valid && tx_ready && (tx_data == 8'h72)));

  assert_ren_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    buf_ren |=> !buf_ren);

  assert_ren_no_tx_R9: assert property (@(posedge clk) disable iff (rst)
    buf_ren |-> !tx_valid);
endmodule

bind capture_host_ctrl capture_host_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_data  (tx_data),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .cap_arm  (cap_arm),
  .buf_ren  (buf_ren)
);

// File: tb/capture_host_ctrl_bench.sv
module capture_host_ctrl_bench;
  localparam int DEPTH = 128;
  localparam int LOGN  = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic       cap_arm;
  logic       cap_done = 1'b0;
  logic       buf_ren;
  logic [6:0] buf_raddr;
  logic [7:0] buf_rdata = 8'h00;

  always #2.5 clk = ~clk;

  capture_host_ctrl #(.DEPTH(DEPTH)) u_capture_host_ctrl (
    .clk(clk), .rst(rst),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .cap_arm(cap_arm), .cap_done(cap_done),
    .buf_ren(buf_ren), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
  );

  int checks = 0;
  int failures = 0;

  function automatic logic [7:0] mem_val(input int a);
    return 8'((a * 37) ^ 8'hA5);
  endfunction

  // buffer model: one cycle read latency
  always @(posedge clk) if (buf_ren) buf_rdata <= mem_val(int'(buf_raddr));

  // capture engine model
  int eng_delay = 30;
  int eng_cnt = 0;
  always @(posedge clk) begin
    if (cap_arm) begin
      eng_cnt  <= eng_delay;
      cap_done <= 1'b0;
    end else if (eng_cnt > 0) begin
      eng_cnt  <= eng_cnt - 1;
      cap_done <= (eng_cnt == 1);
    end else begin
      cap_done <= 1'b0;
    end
  end

  // transmit sink with optional back-pressure
  bit stall = 1'b0;
  bit hold_off = 1'b1;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tx_ready <= hold_off ? 1'b0 : (stall ? (cyc % 3 != 0) : 1'b1);

  logic [7:0] log_q [LOGN];
  int log_n = 0;
  int arm_n = 0;
  int ren_dbl = 0;
  logic ren_prev = 1'b0;
  always @(posedge clk) begin
    if (!rst) begin
      if (tx_valid && tx_ready) begin
        if (log_n < LOGN) log_q[log_n] <= tx_data;
        log_n <= log_n + 1;
      end
      if (cap_arm) arm_n <= arm_n + 1;
      if (buf_ren && ren_prev) ren_dbl <= ren_dbl + 1;
    end
    ren_prev <= buf_ren;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic check_dump(input int base, input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (log_q[base + i] !== mem_val(i)) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    check(bad == 0, req, (first < 0) ? 0 : int'(log_q[base + first]),
          (first < 0) ? 0 : int'(mem_val(first)));
  endtask

  // {command, expected byte count, expected arm pulses}
  localparam logic [27:0] VEC [8] = '{
    {8'h41, 16'd0,   4'd0},
    {8'h54, 16'd128, 4'd0},
    {8'h54, 16'd128, 4'd0},
    {8'h00, 16'd0,   4'd0},
    {8'h52, 16'd2,   4'd1},
    {8'h74, 16'd0,   4'd0},
    {8'hFF, 16'd0,   4'd0},
    {8'h72, 16'd0,   4'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", log_n, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base, abase;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state, before the first edge out of reset
    check(tx_valid == 1'b0, "R1 reset tx_valid", tx_valid, 0);
    check(cap_arm == 1'b0, "R10 reset cap_arm", cap_arm, 0);
    check(buf_ren == 1'b0, "R9 reset buf_ren", buf_ren, 0);

    // R7: ready byte held under back-pressure, no arm yet
    repeat (10) @(negedge clk);
    check(tx_valid == 1'b1, "R7 valid held", tx_valid, 1);
    check(tx_data == 8'h72, "R1 ready code", tx_data, 8'h72);
    check(arm_n == 0, "R1 no arm before accept", arm_n, 0);
    hold_off = 1'b0;
    repeat (100) @(negedge clk);
    check(arm_n == 1, "R1 arm count", arm_n, 1);
    check(log_n == 2, "R2 byte count", log_n, 2);
    check(log_q[0] == 8'h72, "R1 first byte", log_q[0], 8'h72);
    check(log_q[1] == 8'h66, "R2 finish byte", log_q[1], 8'h66);

    // vector table, with back-pressure on the transmitter
    stall = 1'b1;
    for (int v = 0; v < 8; v++) begin
      logic [7:0] c;
      int nb, na;
      c  = VEC[v][27:20];
      nb = int'(VEC[v][19:4]);
      na = int'(VEC[v][3:0]);
      base  = log_n;
      abase = arm_n;
      send_byte(c);
      repeat (1500) @(negedge clk);
      if (nb == 0)
        check(log_n - base == 0, "R5 ignored byte no tx", log_n - base, 0);
      else if (c == 8'h54)
        check(log_n - base == nb, (v == 2) ? "R6 repeat dump count" : "R4 dump count", log_n - base, nb);
      else
        check(log_n - base == nb, "R3 restart byte count", log_n - base, nb);
      check(arm_n - abase == na, (na != 0) ? "R3 restart arm" : "R5 no arm", arm_n - abase, na);
      if (c == 8'h54) check_dump(base, (v == 2) ? "R6 repeat dump content" : "R4 R9 dump content");
      if (c == 8'h52) begin
        check(log_q[base] == 8'h72, "R3 ready again", log_q[base], 8'h72);
        check(log_q[base + 1] == 8'h66, "R3 finish again", log_q[base + 1], 8'h66);
      end
    end
    stall = 1'b0;

    // R8: commands during capture are dropped
    eng_delay = 200;
    base  = log_n;
    abase = arm_n;
    send_byte(8'h52);
    repeat (20) @(negedge clk);
    send_byte(8'h54);
    send_byte(8'h52);
    repeat (400) @(negedge clk);
    check(log_n - base == 2, "R8 capture drop count", log_n - base, 2);
    check(arm_n - abase == 1, "R8 capture drop arm", arm_n - abase, 1);

    // R8: commands during a dump are dropped
    base  = log_n;
    abase = arm_n;
    send_byte(8'h54);
    repeat (50) @(negedge clk);
    send_byte(8'h52);
    send_byte(8'h54);
    repeat (1500) @(negedge clk);
    check(log_n - base == DEPTH, "R8 dump drop count", log_n - base, DEPTH);
    check(arm_n - abase == 0, "R8 dump drop arm", arm_n - abase, 0);
    check_dump(base, "R8 dump content");

    check(ren_dbl == 0, "R9 read pulse width", ren_dbl, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule